// File: doc/BRIEF.md
# Millisecond Tick Corrector

This block turns a 32768 Hz tick into an overflow event whose period averages exactly one millisecond. A millisecond is not a whole number of ticks at that rate (about 32.768), so the up-counter is reloaded after each overflow with one of two values. The short value gives 32 ticks to the next overflow and the long value gives 33. A signed correction accumulator chooses between them. When the accumulator is negative, the long reload is used and the positive correction is added. Otherwise the short reload is used and the negative correction is added. With the reset corrections (+232000 and -768000), 768 of every 1000 periods are long, which totals 32768 ticks per 1000 periods.

Overflow events drive an interrupt flag through a masking counter. The counter is compared with a wrap value, so only every (wrap+1)-th overflow sets the flag and the overflows between are swallowed.

Software writes the corrections, the count, the mask counter and the wrap value through a posted write port. Each write is held in a staging slot with its own pending bit, and the staged value takes effect on the next tick. The counting logic therefore only changes state on tick cycles.

Top module: `ms_tick_corrector`

## Requirements
- R1: After reset, the count is 0xFFFFFFE0, the accumulator is 0, the positive correction is 0x00038A40, the negative correction is 0xFFF44800, the wrap value and the mask counter are 0, `irq` is 0 and `wr_pend` is 0, so the first overflow comes on the 32nd tick.
- R2: The count advances by one only on a cycle with `tick_en` high. A tick that finds the count at all ones is an overflow and reloads the count instead of advancing it.
- R3: On an overflow with a negative accumulator, the count reloads to 0xFFFFFFDF (33 ticks) and the positive correction is added. Otherwise it reloads to 0xFFFFFFE0 (32 ticks) and the negative correction is added. From reset, the first eight periods are 32, 32, 33, 33, 33, 33, 32, 33 ticks.
- R4: With the reset corrections, the 1000 periods from the 1st to the 1001st overflow take exactly 32768 ticks, and every period is 32 or 33 ticks.
- R5: An overflow sets the interrupt flag only when the mask counter equals the wrap value, and the counter then returns to 0. On any other overflow the counter increments. A wrap value of 0 lets every overflow through.
- R6: `irq` stays high until a write to select 5 with `wr_data[0]`=1. Such a write with `wr_data[0]`=0 has no effect. An overflow that sets the flag wins over a clear in the same cycle.
- R7: A write to select 0 (positive correction), 1 (negative correction), 2 (count), 3 (mask counter) or 4 (wrap value) sets `wr_pend` bit equal to the select in the next cycle. The value takes effect at the first tick after the write cycle, and the pending bit drops at that same edge.
- R8: A staged count replaces the count at its applying tick, and that tick does not also advance the count.
- R9: A staged mask counter value replaces the mask counter and so shifts which overflow raises `irq`.
- R10: Staged corrections steer the dithering. With a positive correction of +1 and a negative correction of -1, the periods after reset are 32, 32, 33, 32, 33 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle enable per 32768 Hz tick |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Write target: 0 positive correction, 1 negative correction, 2 count, 3 mask counter, 4 wrap value, 5 flag clear |
| wr_data | input | 32 | Write data |
| wr_pend | output | 5 | Per-target posted-write pending bits, indexed by select |
| irq | output | 1 | Sticky overflow interrupt flag |

## Verification
The dithering is tried three ways:
- A short table of the first eight periods after reset, which pins the sign rule and its ordering.
- A run of 1001 overflows, which shows that the long-to-short ratio closes exactly on 32768 ticks rather than drifting by one.
- A pair of +1/-1 corrections, which should give strict alternation and so separates the choice of correction from the choice of reload.

The masking path is driven with nonzero wrap values and a preloaded mask counter, which shows where the counter resets. Posted writes are checked for pending timing, for a count that lands without an extra increment, and for a clear that collides with an overflow.

// File: rtl/mtc_pkg.sv
package mtc_pkg;

   localparam int unsigned SEL_W      = 3;
   localparam int unsigned NUM_POSTED = 5;

   typedef enum logic [SEL_W-1:0] {
      SEL_PINC = 3'd0,
      SEL_NINC = 3'd1,
      SEL_CNT  = 3'd2,
      SEL_OCNT = 3'd3,
      SEL_WRAP = 3'd4,
      SEL_CLR  = 3'd5
   } mtc_sel_e;

endpackage

// File: rtl/mtc_post_slot.sv
module mtc_post_slot #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   input  logic         tick,
   output logic         pend,
   output logic [W-1:0] stage,
   output logic         apply
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend  <= 1'b0;
         stage <= '0;
      end else if (wr) begin
         pend  <= 1'b1;
         stage <= wdata;
      end else if (tick) begin
         pend  <= 1'b0;
      end
   end

   // a write landing on a tick cycle waits for the following tick
   assign apply = pend & tick & ~wr;

   a_r7_set_pend: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> pend);
   a_r7_drop_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && tick && !wr) |=> !pend);
   a_r7_hold_stage: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && !tick && !wr) |=> (pend && $stable(stage)));

endmodule

// File: rtl/mtc_dither.sv
module mtc_dither #(
   parameter int unsigned      CNT_W       = 32,
   parameter int unsigned      ACC_W       = 32,
   parameter int unsigned      SHORT_TICKS = 32,
   parameter logic [ACC_W-1:0] PINC_RST    = '0,
   parameter logic [ACC_W-1:0] NINC_RST    = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             cnt_ld,
   input  logic [CNT_W-1:0] cnt_ld_val,
   input  logic             pinc_ld,
   input  logic [ACC_W-1:0] pinc_val,
   input  logic             ninc_ld,
   input  logic [ACC_W-1:0] ninc_val,
   output logic             ovf
);

   localparam logic [CNT_W-1:0] CNT_MAX    = '1;
   localparam logic [CNT_W-1:0] LOAD_SHORT = ~CNT_W'(SHORT_TICKS - 1);
   localparam logic [CNT_W-1:0] LOAD_LONG  = ~CNT_W'(SHORT_TICKS);

   logic [CNT_W-1:0] cnt;
   logic [ACC_W-1:0] acc;
   logic [ACC_W-1:0] pinc;
   logic [ACC_W-1:0] ninc;
   logic             at_max;
   logic             acc_neg;

   assign at_max  = (cnt == CNT_MAX);
   assign acc_neg = acc[ACC_W-1];
   assign ovf     = tick & at_max & ~cnt_ld;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pinc <= PINC_RST;
         ninc <= NINC_RST;
      end else begin
         if (pinc_ld) pinc <= pinc_val;
         if (ninc_ld) ninc <= ninc_val;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= LOAD_SHORT;
         acc <= '0;
      end else if (cnt_ld) begin
         cnt <= cnt_ld_val;
      end else if (ovf) begin
         cnt <= acc_neg ? LOAD_LONG : LOAD_SHORT;
         acc <= acc + (acc_neg ? pinc : ninc);
      end else if (tick) begin
         cnt <= cnt + CNT_W'(1);
      end
   end

   a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !cnt_ld && !at_max) |=> (cnt == $past(cnt) + CNT_W'(1)));
   a_r2_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !cnt_ld) |=> $stable(cnt));
   a_r3_long: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && acc_neg) |=> (cnt == LOAD_LONG));
   a_r3_short: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !acc_neg) |=> (cnt == LOAD_SHORT));
   a_r8_replace: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_ld |=> (cnt == $past(cnt_ld_val)));

endmodule

// File: rtl/mtc_ovf_mask.sv
module mtc_ovf_mask #(
   parameter int unsigned OVF_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ovf,
   input  logic             ocnt_ld,
   input  logic [OVF_W-1:0] ocnt_val,
   input  logic             wrap_ld,
   input  logic [OVF_W-1:0] wrap_val,
   input  logic             clr,
   output logic             flag
);

   logic [OVF_W-1:0] ocnt;
   logic [OVF_W-1:0] wrap;
   logic             hit;

   assign hit = ovf & (ocnt == wrap);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ocnt <= '0;
         wrap <= '0;
      end else begin
         if (wrap_ld) wrap <= wrap_val;
         if (ocnt_ld)  ocnt <= ocnt_val;
         else if (ovf) ocnt <= hit ? '0 : ocnt + OVF_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   flag <= 1'b0;
      else if (hit) flag <= 1'b1;
      else if (clr) flag <= 1'b0;
   end

   a_r5_rise_on_ovf: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> $past(ovf));
   a_r5_masked_step: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !ocnt_ld && (ocnt != wrap)) |=> (ocnt == $past(ocnt) + OVF_W'(1)));
   a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !clr) |=> flag);
   a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !hit) |=> !flag);

endmodule

// File: rtl/ms_tick_corrector.sv
module ms_tick_corrector import mtc_pkg::*; #(
   parameter int unsigned      DATA_W      = 32,
   parameter int unsigned      CNT_W       = 32,
   parameter int unsigned      ACC_W       = 32,
   parameter int unsigned      OVF_W       = 24,
   parameter int unsigned      SHORT_TICKS = 32,
   parameter logic [ACC_W-1:0] PINC_RST    = 32'h0003_8A40,
   parameter logic [ACC_W-1:0] NINC_RST    = 32'hFFF4_4800
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  tick_en,
   input  logic                  wr_en,
   input  logic [SEL_W-1:0]      wr_sel,
   input  logic [DATA_W-1:0]     wr_data,
   output logic [NUM_POSTED-1:0] wr_pend,
   output logic                  irq
);

   if (CNT_W > DATA_W) begin : g_bad_cnt_w
      $error("CNT_W must not exceed DATA_W");
   end
   if (ACC_W != DATA_W) begin : g_bad_acc_w
      $error("ACC_W must equal DATA_W");
   end
   if (OVF_W > DATA_W) begin : g_bad_ovf_w
      $error("OVF_W must not exceed DATA_W");
   end
   if (SHORT_TICKS < 2) begin : g_bad_short
      $error("SHORT_TICKS must be at least 2");
   end

   logic [ACC_W-1:0] inc_stage [2];
   logic [1:0]       inc_apply;
   logic [OVF_W-1:0] ovf_stage [2];
   logic [1:0]       ovf_apply;
   logic [CNT_W-1:0] cnt_stage;
   logic             cnt_apply;
   logic             ovf_evt;
   logic             clr;

   // correction slots: select 0 and 1
   for (genvar i = 0; i < 2; i++) begin : g_inc_slot
      mtc_post_slot #(.W(ACC_W)) u_slot (
         .clk   (clk),
         .rst_n (rst_n),
         .wr    (wr_en && (wr_sel == SEL_W'(int'(SEL_PINC) + i))),
         .wdata (wr_data[ACC_W-1:0]),
         .tick  (tick_en),
         .pend  (wr_pend[int'(SEL_PINC) + i]),
         .stage (inc_stage[i]),
         .apply (inc_apply[i])
      );
   end

   mtc_post_slot #(.W(CNT_W)) u_cnt_slot (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (wr_en && (wr_sel == SEL_CNT)),
      .wdata (wr_data[CNT_W-1:0]),
      .tick  (tick_en),
      .pend  (wr_pend[int'(SEL_CNT)]),
      .stage (cnt_stage),
      .apply (cnt_apply)
   );

   // mask slots: select 3 and 4
   for (genvar j = 0; j < 2; j++) begin : g_ovf_slot
      mtc_post_slot #(.W(OVF_W)) u_slot (
         .clk   (clk),
         .rst_n (rst_n),
         .wr    (wr_en && (wr_sel == SEL_W'(int'(SEL_OCNT) + j))),
         .wdata (wr_data[OVF_W-1:0]),
         .tick  (tick_en),
         .pend  (wr_pend[int'(SEL_OCNT) + j]),
         .stage (ovf_stage[j]),
         .apply (ovf_apply[j])
      );
   end

   assign clr = wr_en && (wr_sel == SEL_CLR) && wr_data[0];

   mtc_dither #(
      .CNT_W       (CNT_W),
      .ACC_W       (ACC_W),
      .SHORT_TICKS (SHORT_TICKS),
      .PINC_RST    (PINC_RST),
      .NINC_RST    (NINC_RST)
   ) u_dither (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick_en),
      .cnt_ld     (cnt_apply),
      .cnt_ld_val (cnt_stage),
      .pinc_ld    (inc_apply[0]),
      .pinc_val   (inc_stage[0]),
      .ninc_ld    (inc_apply[1]),
      .ninc_val   (inc_stage[1]),
      .ovf        (ovf_evt)
   );

   mtc_ovf_mask #(.OVF_W(OVF_W)) u_mask (
      .clk      (clk),
      .rst_n    (rst_n),
      .ovf      (ovf_evt),
      .ocnt_ld  (ovf_apply[0]),
      .ocnt_val (ovf_stage[0]),
      .wrap_ld  (ovf_apply[1]),
      .wrap_val (ovf_stage[1]),
      .clr      (clr),
      .flag     (irq)
   );

   a_r2_no_ovf_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_en |-> !ovf_evt);

endmodule

// File: tb/test_ms_tick_corrector.sv
module test_ms_tick_corrector;

   localparam int CLK_PERIOD = 10;
   localparam int unsigned EXP_PER [8] = '{32, 32, 33, 33, 33, 33, 32, 33};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_sel = 3'd0;
   logic [31:0] wr_data = 32'd0;
   logic [4:0]  wr_pend;
   logic        irq;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   ms_tick_corrector i_ms_tick_corrector (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_en (tick_en),
      .wr_en   (wr_en),
      .wr_sel  (wr_sel),
      .wr_data (wr_data),
      .wr_pend (wr_pend),
      .irq     (irq)
   );

   task automatic check(input string req, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; tick_en = 1'b0; wr_en = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic tick();
      tick_en = 1'b1;
      @(negedge clk);
      tick_en = 1'b0;
      @(negedge clk);
   endtask

   task automatic write(input logic [2:0] sel, input logic [31:0] data);
      wr_en = 1'b1; wr_sel = sel; wr_data = data;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic ticks_to_irq(output int n);
      n = 0;
      while (!irq && n < 200) begin
         tick();
         n++;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      int n;
      int sum;
      int odd;

      // R1: reset state
      do_reset();
      check("R1 irq", irq, 0);
      check("R1 wr_pend", wr_pend, 0);

      // R3 / R1 / R2: period table after reset
      for (int k = 0; k < 8; k++) begin
         ticks_to_irq(n);
         check($sformatf("R3 period %0d", k), n, EXP_PER[k]);
         write(3'd5, 32'd1);
      end

      // R4: 1000 periods between 1st and 1001st overflow
      do_reset();
      ticks_to_irq(n);
      write(3'd5, 32'd1);
      sum = 0;
      odd = 0;
      for (int k = 0; k < 1000; k++) begin
         ticks_to_irq(n);
         sum += n;
         if (n != 32 && n != 33) odd++;
         write(3'd5, 32'd1);
      end
      check("R4 total ticks", sum, 32768);
      check("R4 periods outside 32..33", odd, 0);

      // R5: wrap 2 -> every third overflow
      do_reset();
      write(3'd4, 32'd2);
      ticks_to_irq(n);
      check("R5 first unmasked", n, 97);
      write(3'd5, 32'd1);
      ticks_to_irq(n);
      check("R5 second unmasked", n, 99);

      // R9: mask counter preload
      do_reset();
      write(3'd4, 32'd3);
      write(3'd3, 32'd2);
      ticks_to_irq(n);
      check("R9 preloaded mask", n, 64);

      // R6: sticky flag, zero-bit write ignored, clear
      do_reset();
      ticks_to_irq(n);
      for (int k = 0; k < 40; k++) tick();
      check("R6 sticky", irq, 1);
      write(3'd5, 32'hFFFF_FFFE);
      check("R6 clear bit0=0 ignored", irq, 1);
      write(3'd5, 32'd1);
      check("R6 cleared", irq, 0);

      // R6: overflow wins over clear in the same cycle
      do_reset();
      for (int k = 0; k < 31; k++) tick();
      check("R6 no irq before 32nd tick", irq, 0);
      tick_en = 1'b1; wr_en = 1'b1; wr_sel = 3'd5; wr_data = 32'd1;
      @(negedge clk);
      tick_en = 1'b0; wr_en = 1'b0;
      check("R6 set wins", irq, 1);

      // R7: pending bits
      do_reset();
      write(3'd1, 32'hFFF4_4800);
      check("R7 pend set", wr_pend, 5'b00010);
      repeat (5) @(negedge clk);
      check("R7 pend held", wr_pend, 5'b00010);
      tick();
      check("R7 pend dropped", wr_pend, 5'b00000);
      write(3'd4, 32'd0);
      check("R7 wrap pend", wr_pend, 5'b10000);
      tick();
      check("R7 wrap pend dropped", wr_pend, 5'b00000);

      // R8: count write replaces count at apply tick
      do_reset();
      write(3'd2, 32'hFFFF_FFFD);
      check("R8 pend", wr_pend, 5'b00100);
      ticks_to_irq(n);
      check("R8 ticks to overflow", n, 4);

      // R10: +1 / -1 corrections alternate
      do_reset();
      write(3'd0, 32'd1);
      write(3'd1, 32'hFFFF_FFFF);
      for (int k = 0; k < 5; k++) begin
         ticks_to_irq(n);
         check($sformatf("R10 period %0d", k), n, (k == 2 || k == 4) ? 33 : 32);
         write(3'd5, 32'd1);
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule